// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave that lets a host read and write a small bank of 8-bit control registers over a two-wire open-drain bus. It is meant for things like per-output clock enable bits. The host may never touch the bank at all, because every register comes out of reset holding a fixed default value. Every register is always visible on a flat parallel output bus, which the rest of the chip reads directly.

A command byte that follows the address selects the mode. With its top bit set, the command makes an indexed access to one register, and its low seven bits give the offset. With its top bit clear, it starts a counted block transfer that walks the registers upward from offset 0. A block write carries a byte-count byte before the data. A block read first returns the bank size and then the register contents.

The SCL and SDA wires are oversampled by the system clock through synchronizers. The only output toward the bus is a pull-low enable for SDA.

Top module: `smb_reg_slave`

## Requirements
- R1: During and after reset, `regs_o` holds the parameter defaults. Register i occupies bits [8i+7:8i]. The SDA pull-low enable is off.
- R2: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read), that is, 7-bit address 0x69. For any other address it gives no acknowledge to that byte or to any later byte, until the next START.
- R3: A byte write (address write, command with bit 7 = 1 and offset in bits 6:0, one data byte) is acknowledged on every byte and loads the addressed register.
- R4: A byte read (address write, command with bit 7 = 1, repeated START, address read) returns the addressed register, most significant bit first.
- R5: A block write (command 0x00, a byte-count byte, then data) is acknowledged on every byte. It loads the registers in ascending order from offset 0.
- R6: A block read (command 0x00, repeated START, address read) returns the count 8 and then registers 0, 1, 2 and so on in order. After the master's not-acknowledge, the slave releases SDA.
- R7: A STOP after any complete data byte ends the transfer. Registers written before the STOP keep their new values. A data byte cut off by the STOP before its eighth bit is not written.
- R8: A byte-mode offset of 8 or more is acknowledged, but a write to it changes nothing. A read at such an offset returns 0x00, and so does a block read past the last register.
- R9: A block write with more than 8 data bytes acknowledges all of them. Bytes beyond register 7 are discarded.
- R10: A START seen at any bit position aborts the byte in progress. The transaction that follows it is decoded correctly.
- R11: The slave changes its SDA pull-low only while SCL is low, and it releases SDA right after a STOP.
- R12: Register contents change only when a data byte of a write transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND with the slave's pull-low) |
| sda_pull_o | output | 1 | 1 = slave pulls SDA low |
| regs_o | output | NREG*8 | Flat register bank, register i at bits [8i+7:8i] |

## Verification
A wrong bit counter or state shows up at the ports as an acknowledge in the wrong bit slot. The master then reads back a shifted or corrupted byte within the same transfer. A wrong block pointer or a lost count-first flag first appears in the count byte or the first data byte of the next block read, or in `regs_o` within a few cycles of the ninth clock of a write byte. A pull-low that is not released blocks the following STOP or START, and the master sees this on the very next bit.

// File: rtl/smb_pkg.sv
// Shared types for the two-wire register slave.
// Assumes: byte-wide registers and 4-bit bit counting (0..9 per byte slot).
package smb_pkg;
    localparam int BYTE_W = 8;
    localparam int BITC_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_CMD   = 3'd2,
        ST_COUNT = 3'd3,
        ST_WDATA = 3'd4,
        ST_TX    = 3'd5,
        ST_SKIP  = 3'd6
    } link_st_t;
endpackage

// File: rtl/smb_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and derives SCL edges
// and START/STOP conditions.
// Assumes: each bus level is held for several system clocks, and both lines
// pass through identical delays, so their relative order is preserved.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chains plus one history flop; reset to the idle (high) bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_reg_bank.sv
// Bank of NREG byte registers with reset defaults, one write port and one
// read port.
// Assumes: wr_idx and rd_idx are byte-wide pointers; indices at or past
// NREG write nothing and read as zero.
module smb_reg_bank #(
    parameter int                NREG     = 8,
    parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [7:0] q;
        // One register: load its default on reset, take data on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= DEFAULTS[g*8 +: 8];
            end else if (wr_en && (wr_idx == 8'(g))) begin
                q <= wr_data;
            end
        end
        assign regs_flat[g*8 +: 8] = q;
    end

    // Read multiplexer; out-of-range pointers return zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx == 8'(i)) rd_data = regs_flat[i*8 +: 8];
        end
    end
endmodule

// File: rtl/smb_link_fsm.sv
// Bit and byte protocol engine. It receives bytes on SCL rising edges, drives
// the acknowledge and read data after SCL falling edges, and decodes the
// address, command, count and data phases.
// Assumes: a START or STOP resets the byte machine; the mode and pointer set
// by the last command survive a repeated START.
module smb_link_fsm
    import smb_pkg::*;
#(
    parameter int         NREG  = 8,
    parameter logic [6:0] ADDR7 = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_idx,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       sda_pull
);
    localparam logic [7:0] COUNT_B = 8'(NREG);

    link_st_t          state;
    link_st_t          nxt;
    logic [BITC_W-1:0] bitcnt;
    logic [7:0]        shreg;
    logic [7:0]        tx;
    logic [7:0]        ptr;
    logic              nack;
    logic              byte_mode;
    logic              cnt_pend;
    logic [7:0]        tx_next;

    // Next byte to send: the bank size first in a block read, then register data.
    assign tx_next = cnt_pend ? COUNT_B : rd_data;
    assign rd_idx  = ptr;

    function automatic logic [7:0] bump(input logic [7:0] p);
        return (p == 8'hFF) ? p : p + 8'd1;
    endfunction

    // Protocol sequencer: bit counting, acknowledge, transmit shifting, writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            nxt       <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            tx        <= '0;
            ptr       <= '0;
            nack      <= 1'b0;
            byte_mode <= 1'b0;
            cnt_pend  <= 1'b0;
            sda_pull  <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    if (bitcnt < 4'd9) bitcnt <= bitcnt + 4'd1;
                    if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_s};
                    if (bitcnt == 4'd8) nack <= sda_s;
                end else if (scl_fall && state == ST_TX) begin
                    if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                        tx       <= {tx[6:0], 1'b0};
                        sda_pull <= ~tx[6];
                    end else if (bitcnt == 4'd8) begin
                        sda_pull <= 1'b0;
                    end else if (bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        if (nack) begin
                            state <= ST_SKIP;
                        end else begin
                            tx       <= tx_next;
                            sda_pull <= ~tx_next[7];
                            if (cnt_pend) cnt_pend <= 1'b0;
                            else          ptr      <= bump(ptr);
                        end
                    end
                end else if (scl_fall && state != ST_SKIP) begin
                    if (bitcnt == 4'd8) begin
                        sda_pull <= 1'b1;
                        unique case (state)
                            ST_ADDR: begin
                                if (shreg[7:1] != ADDR7) begin
                                    sda_pull <= 1'b0;
                                    state    <= ST_SKIP;
                                end
                                nxt <= shreg[0] ? ST_TX : ST_CMD;
                            end
                            ST_CMD: begin
                                byte_mode <= shreg[7];
                                ptr       <= shreg[7] ? {1'b0, shreg[6:0]} : 8'h00;
                                cnt_pend  <= ~shreg[7];
                                nxt       <= shreg[7] ? ST_WDATA : ST_COUNT;
                            end
                            ST_COUNT: nxt <= ST_WDATA;
                            default: begin
                                if (ptr < COUNT_B) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr;
                                    wr_data <= shreg;
                                end
                                ptr <= byte_mode ? 8'hFF : bump(ptr);
                                nxt <= ST_WDATA;
                            end
                        endcase
                    end else if (bitcnt == 4'd9) begin
                        sda_pull <= 1'b0;
                        bitcnt   <= '0;
                        state    <= nxt;
                        if (nxt == ST_TX) begin
                            tx       <= tx_next;
                            sda_pull <= ~tx_next[7];
                            if (cnt_pend) cnt_pend <= 1'b0;
                            else          ptr      <= bump(ptr);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/smb_reg_slave.sv
// Top level of the two-wire control register slave: line synchronizer,
// protocol engine and register bank.
// Assumes: the bus is oversampled by clk at several times the SCL rate.
module smb_reg_slave #(
    parameter int                NREG     = 8,
    parameter logic [6:0]        ADDR7    = 7'h69,
    parameter logic [NREG*8-1:0] DEFAULTS = 64'h7F3C_5AA5_FF00_C3E1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [NREG*8-1:0] regs_o
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en;
    logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

    smb_line_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_link_fsm #(.NREG(NREG), .ADDR7(ADDR7)) link_i (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .sda_pull(sda_pull_o)
    );

    smb_reg_bank #(.NREG(NREG), .DEFAULTS(DEFAULTS)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .regs_flat(regs_o)
    );
endmodule

// File: rtl/smb_reg_slave_chk.sv
// Property checker for smb_reg_slave, attached with bind.
// Assumes: it observes the synchronized SCL, the STOP strobe and the write
// port between the protocol engine and the bank.
module smb_reg_slave_chk #(
    parameter int NREG = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              stop_det,
    input logic              sda_pull,
    input logic              wr_en,
    input logic [7:0]        wr_idx,
    input logic [NREG*8-1:0] regs
);
    // R11: the pull-low only moves while SCL is low.
    p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s);

    // R11: SDA is free in the cycle after a STOP.
    p_release_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

    // R12: the bank changes only after a write strobe from the engine.
    p_write_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs) |-> $past(wr_en));

    // R8 and R9: the engine never issues a write past the last register.
    p_wr_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < 8'(NREG)));

    // R1: while reset is held, the slave does not pull SDA.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !sda_pull);
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.NREG(NREG)) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
    .sda_pull(sda_pull_o), .wr_en(wr_en), .wr_idx(wr_idx), .regs(regs_o)
);

// File: tb/smb_reg_slave_tb.sv
// Bench for smb_reg_slave: a bus master model with directed corner cases and
// seeded random transfers, checked against a bench-side register model.
module smb_reg_slave_tb_top;
    localparam int Q = 10;
    localparam logic [63:0] DEF = 64'h7F3C_5AA5_FF00_C3E1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [63:0] regs;
    logic sda_line;
    int checks = 0;
    int errors = 0;
    logic [7:0] model [8];

    always #4 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    smb_reg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .regs_o(regs)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int i = 0; i < 8; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    function automatic logic [7:0] exp_rd(input int off);
        return (off < 8) ? model[off] : 8'h00;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic wb(input logic [7:0] v, input string req, input logic exp_ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        chk(req, {63'd0, ~a}, {63'd0, exp_ack});
    endtask

    task automatic rb(output logic [7:0] v, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(nack);
    endtask

    task automatic byte_write(input int off, input logic [7:0] d);
        bus_start();
        wb(8'hD2, "R2 addr ack", 1'b1);
        wb(8'h80 | 8'(off), "R3 cmd ack", 1'b1);
        wb(d, "R3 data ack", 1'b1);
        bus_stop();
        if (off < 8) model[off] = d;
        chk("R3 regs after byte write", regs, model_flat());
    endtask

    task automatic byte_read(input int off, input string req);
        logic [7:0] v;
        bus_start();
        wb(8'hD2, "R2 addr ack", 1'b1);
        wb(8'h80 | 8'(off), "R4 cmd ack", 1'b1);
        bus_start();
        wb(8'hD3, "R2 read addr ack", 1'b1);
        rb(v, 1'b1);
        bus_stop();
        chk(req, {56'd0, v}, {56'd0, exp_rd(off)});
    endtask

    task automatic block_write(input int n, input int seed_base);
        logic [7:0] d;
        bus_start();
        wb(8'hD2, "R2 addr ack", 1'b1);
        wb(8'h00, "R5 cmd ack", 1'b1);
        wb(8'(n), "R5 count ack", 1'b1);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom) ^ 8'(seed_base);
            wb(d, (i < 8) ? "R5 data ack" : "R9 extra data ack", 1'b1);
            if (i < 8) model[i] = d;
        end
        bus_stop();
        chk("R5 R9 regs after block write", regs, model_flat());
    endtask

    task automatic block_read(input int k);
        logic [7:0] v;
        bus_start();
        wb(8'hD2, "R2 addr ack", 1'b1);
        wb(8'h00, "R6 cmd ack", 1'b1);
        bus_start();
        wb(8'hD3, "R2 read addr ack", 1'b1);
        rb(v, 1'b0);
        chk("R6 count byte", {56'd0, v}, 64'd8);
        for (int i = 0; i < k; i++) begin
            rb(v, (i == k - 1));
            chk("R6 R8 block read data", {56'd0, v}, {56'd0, exp_rd(i)});
        end
        chk("R6 SDA released after nack", {63'd0, sda_pull}, 64'd0);
        bus_stop();
        chk("R11 SDA free after stop", {63'd0, sda_pull}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        for (int i = 0; i < 8; i++) model[i] = DEF[i*8 +: 8];
        tick(5);
        chk("R1 defaults in reset", regs, DEF);
        rst_n = 1'b1;
        tick(4);
        chk("R1 defaults after reset", regs, DEF);
        chk("R1 no pull after reset", {63'd0, sda_pull}, 64'd0);

        byte_write(3, 8'h5C);
        byte_read(3, "R4 byte read of written reg");
        byte_read(6, "R4 byte read of default reg");

        block_write(8, 8'h11);
        block_read(8);

        byte_write(8'h45, 8'hAA);
        chk("R8 out-of-range write ignored", regs, model_flat());
        byte_read(8'h45, "R8 out-of-range read is zero");
        block_read(9);

        block_write(11, 8'h3C);

        // R7: STOP cut into the third data byte; the first two bytes stay written.
        bus_start();
        wb(8'hD2, "R2 addr ack", 1'b1);
        wb(8'h00, "R7 cmd ack", 1'b1);
        wb(8'd5, "R7 count ack", 1'b1);
        wb(8'h96, "R7 data0 ack", 1'b1); model[0] = 8'h96;
        wb(8'h69, "R7 data1 ack", 1'b1); model[1] = 8'h69;
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        chk("R7 partial byte not written", regs, model_flat());

        // R2: a foreign address draws no acknowledge on any byte.
        bus_start();
        wb(8'hA4, "R2 foreign addr nack", 1'b0);
        wb(8'h81, "R2 later byte nack", 1'b0);
        wb(8'h00, "R2 later byte nack", 1'b0);
        bus_stop();
        chk("R2 foreign write ignored", regs, model_flat());

        // R10: a START in the middle of the command byte aborts it.
        bus_start();
        wb(8'hD2, "R2 addr ack", 1'b1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        byte_read(1, "R10 read after mid-byte start");

        for (int t = 0; t < 25; t++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: byte_write(int'($urandom % 10), 8'($urandom));
                1: byte_read(int'($urandom % 10), "R4 R8 random byte read");
                2: block_write(1 + int'($urandom % 10), t);
                default: block_read(1 + int'($urandom % 9));
            endcase
        end

        tick(10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule